// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

A single DMA channel that executes transfers described by an eight-word transfer descriptor held in memory. The descriptor gives the channel a source and a destination address, two signed per-beat address steps, the number of bytes to move per start (one minor loop), an iteration count that makes up a major loop, two signed end-of-major address corrections and a control word. Every start moves exactly one minor loop, as beats of either 1 or 4 bytes. Each beat is a read from the source followed by a write to the destination over a simple memory port. Byte beats carry data right-aligned on the data bus.

A start can come from a software pulse, from a link pulse driven by another channel, or from a level hardware request while the request enable is set. At the end of a minor loop the channel can signal a link to another channel. At the end of the major loop it can signal a different link, raise a sticky interrupt and drop its request enable. In scatter-gather mode it fetches the next descriptor from memory instead of correcting the destination address. The first descriptor is fetched the same way, from an address given with a load pulse.

Descriptor layout, one 32-bit little-endian word per offset of 4 bytes:
- word 0: source address
- word 1: destination address
- word 2: bits 31:16 source step, bits 15:0 destination step, both signed
- word 3: minor-loop byte count
- word 4: control
- word 5: signed source end correction
- word 6: signed destination end correction, or the next descriptor address in scatter-gather mode
- word 7: unused

Control word fields:

| Bits | Meaning |
|---|---|
| 15:0 | iteration count |
| 16 | word beats (0 selects byte beats) |
| 17 | interrupt enable |
| 18 | auto-stop |
| 19 | scatter-gather |
| 20 | minor link enable |
| 21 | major link enable |
| 27:24 | minor link channel |
| 31:28 | major link channel |

Top module: `dma_desc_channel`

## Requirements
- R1: A start moves one minor loop of word-3 bytes. The loop is made of beats of 4 bytes when control bit 16 is 1 and 1 byte when it is 0, and ends after the beat that brings the remaining count to zero or below. Each beat is one read cycle at the source (mem_re) followed by one write cycle at the destination (mem_we) carrying the value read. mem_word shows the beat size, and byte data sits in bits 7:0.
- R2: After each beat the source address changes by the signed source step and the destination address by the signed destination step. A step of 0 keeps the address fixed, and negative steps count down.
- R3: When the minor loop that ends the major loop completes, the source correction (word 5) is added to the source address, and, without scatter-gather, the destination correction (word 6) is added to the destination address. The iteration count reloads from the descriptor's value, so the same descriptor runs again from its start.
- R4: With control bit 20 set, the end of every minor loop except the last of the major loop gives a one-cycle link_valid with link_ch equal to bits 27:24.
- R5: With control bit 21 set, the end of the last minor loop gives a one-cycle link_valid with link_ch equal to bits 31:28, and no minor link in that loop.
- R6: With control bit 19 set, the destination correction is not applied at major completion. Instead the channel reads eight words, one per cycle, at word-6 address plus 4×i, and they become the active descriptor before any further start is served.
- R7: With control bit 18 set, req_en clears at major completion. With it clear, req_en keeps its value.
- R8: With control bit 17 set, irq rises at major completion and stays high until an irq_clr pulse.
- R9: A start comes from sw_start, from link_in, or from hw_req while req_en is 1. req_en_set sets req_en, and hw_req has no effect while req_en is 0.
- R10: Start pulses are held until served. Pulses pending together, including sw_start and link_in in the same cycle, produce one minor loop. A pulse that arrives while a minor loop runs produces one more loop afterwards.
- R11: After reset the channel is idle, with irq, req_en, link_valid, mem_re and mem_we low. A boot_load pulse while idle fetches a descriptor of the same layout from boot_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_load | input | 1 | Fetch the first descriptor (pulse, while idle) |
| boot_addr | input | ADDR_W | Address of the first descriptor |
| sw_start | input | 1 | Software start pulse |
| link_in | input | 1 | Start pulse from another channel |
| hw_req | input | 1 | Hardware request level |
| req_en_set | input | 1 | Sets the hardware request enable |
| irq_clr | input | 1 | Clears the interrupt |
| irq | output | 1 | Major-completion interrupt, sticky |
| req_en | output | 1 | Hardware request enable |
| busy | output | 1 | Channel is not idle |
| link_valid | output | 1 | Link pulse to another channel |
| link_ch | output | 4 | Linked channel number |
| mem_re | output | 1 | Memory read cycle |
| mem_we | output | 1 | Memory write cycle |
| mem_word | output | 1 | 1 for a 4-byte access, 0 for a byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read cycle |

## Verification
Two collisions are provoked on purpose. The first is a software start and a link start raised in the same cycle, which must yield exactly one minor loop. The second is a software start raised while a minor loop is already moving data, which must yield exactly one further loop once the first ends. The bench's reference model queues the exact memory accesses and link pulses these cases should produce. Any missing, extra or reordered access or link is reported at the port in the cycle it appears. The other pairing that can meet in one cycle is the major-completion housekeeping (address correction, interrupt, link, auto-stop) in the same step as a scatter-gather fetch. It is judged by the eight fetch reads following the last write, with no destination correction visible in the next descriptor's traffic.

// File: rtl/dma_ch_pkg.sv
// Package: shared constants and state type for the descriptor DMA channel.
// Assumes 32-bit descriptor words and a fixed eight-word descriptor.
package dma_ch_pkg;
    localparam int WORD_W     = 32;
    localparam int OFF_W      = 16;
    localparam int CNT_W      = 16;
    localparam int CH_W       = 4;
    localparam int DESC_WORDS = 8;

    // control word bit positions
    localparam int B_WORD  = 16;
    localparam int B_IRQ   = 17;
    localparam int B_ASTOP = 18;
    localparam int B_SG    = 19;
    localparam int B_MNL   = 20;
    localparam int B_MJL   = 21;
    localparam int B_MNCH  = 24;
    localparam int B_MJCH  = 28;

    typedef enum logic [2:0] {
        S_IDLE, S_RD, S_WR, S_END, S_FETCH
    } ch_state_t;
endpackage

// File: rtl/dma_ch_trigger.sv
// Start collection: holds software and link start pulses until the engine
// accepts a start, and keeps the hardware request enable.
// Assumes accept is high only in a cycle where go is high.
module dma_ch_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic link_in,
    input  logic hw_req,
    input  logic req_en_set,
    input  logic stop_clr,
    input  logic accept,
    output logic go,
    output logic req_en
);
    logic sw_pend, link_pend;

    // hold start pulses; one accept clears everything pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_pend   <= 1'b0;
            link_pend <= 1'b0;
        end else begin
            sw_pend   <= (sw_pend & ~accept) | sw_start;
            link_pend <= (link_pend & ~accept) | link_in;
        end
    end

    // request enable: auto-stop clear wins over a set
    always_ff @(posedge clk) begin
        if (!rst_n)          req_en <= 1'b0;
        else if (stop_clr)   req_en <= 1'b0;
        else if (req_en_set) req_en <= 1'b1;
    end

    assign go = sw_pend | link_pend | (hw_req & req_en);

    assert_start_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start |=> go);
    assert_hw_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sw_pend && !link_pend) |-> (hw_req && req_en));
    assert_reqen_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_en) |-> $past(stop_clr));
endmodule

// File: rtl/dma_ch_engine.sv
// Transfer engine: fetches descriptors, runs minor loops as read/write beat
// pairs, applies end-of-major corrections, links, interrupt and auto-stop.
// Assumes a memory port whose read data is valid in the read cycle.
module dma_ch_engine
    import dma_ch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic                 boot_load,
    input  logic [ADDR_W-1:0]    boot_addr,
    input  logic                 irq_clr,
    output logic                 accept,
    output logic                 stop_clr,
    output logic                 busy,
    output logic                 irq,
    output logic                 link_valid,
    output logic [CH_W-1:0]      link_ch,
    output logic                 mem_re,
    output logic                 mem_we,
    output logic                 mem_word,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata
);
    localparam int IDX_W = $clog2(DESC_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    ch_state_t state;
    logic [ADDR_W-1:0] src_q, dst_q, faddr_q;
    logic [OFF_W-1:0]  soff_q, doff_q;
    logic [WORD_W-1:0] minor_q, rem_q, data_q, slast_q, dlast_q, beat;
    logic [CNT_W-1:0]  citer_q, biter_q;
    logic              word_q, irq_en_q, astop_q, sg_q, mnl_q, mjl_q;
    logic [CH_W-1:0]   mnch_q, mjch_q;
    logic [IDX_W-1:0]  fidx_q;
    logic              last_iter;

    function automatic logic [ADDR_W-1:0] sext(input logic [OFF_W-1:0] o);
        return {{(ADDR_W-OFF_W){o[OFF_W-1]}}, o};
    endfunction

    assign last_iter = (citer_q <= CNT_W'(1));
    assign beat      = word_q ? WORD_W'(4) : WORD_W'(1);
    assign busy      = (state != S_IDLE);
    assign accept    = (state == S_IDLE) && !boot_load && go;
    assign stop_clr  = (state == S_END) && last_iter && astop_q;

    // link output during the end-of-minor cycle
    always_comb begin
        link_valid = (state == S_END) && (last_iter ? mjl_q : mnl_q);
        link_ch    = last_iter ? mjch_q : mnch_q;
    end

    // memory port drive per state
    always_comb begin
        mem_re    = (state == S_RD) || (state == S_FETCH);
        mem_we    = (state == S_WR);
        mem_word  = (state == S_FETCH) ? 1'b1 : word_q;
        mem_wdata = data_q;
        case (state)
            S_RD:    mem_addr = src_q;
            S_WR:    mem_addr = dst_q;
            S_FETCH: mem_addr = faddr_q + ADDR_W'({fidx_q, 2'b00});
            default: mem_addr = '0;
        endcase
    end

    // main sequencer with descriptor registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            src_q <= '0; dst_q <= '0; faddr_q <= '0;
            soff_q <= '0; doff_q <= '0;
            minor_q <= '0; rem_q <= '0; data_q <= '0;
            slast_q <= '0; dlast_q <= '0;
            citer_q <= '0; biter_q <= '0;
            word_q <= 1'b0; irq_en_q <= 1'b0; astop_q <= 1'b0;
            sg_q <= 1'b0; mnl_q <= 1'b0; mjl_q <= 1'b0;
            mnch_q <= '0; mjch_q <= '0; fidx_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (boot_load) begin
                        faddr_q <= boot_addr;
                        fidx_q  <= '0;
                        state   <= S_FETCH;
                    end else if (go) begin
                        rem_q <= minor_q;
                        state <= S_RD;
                    end
                end
                S_RD: begin
                    data_q <= mem_rdata;
                    state  <= S_WR;
                end
                S_WR: begin
                    src_q <= src_q + sext(soff_q);
                    dst_q <= dst_q + sext(doff_q);
                    rem_q <= rem_q - beat;
                    state <= (rem_q <= beat) ? S_END : S_RD;
                end
                S_END: begin
                    if (last_iter) begin
                        src_q   <= src_q + ADDR_W'(slast_q);
                        citer_q <= biter_q;
                        if (sg_q) begin
                            faddr_q <= ADDR_W'(dlast_q);
                            fidx_q  <= '0;
                            state   <= S_FETCH;
                        end else begin
                            dst_q <= dst_q + ADDR_W'(dlast_q);
                            state <= S_IDLE;
                        end
                    end else begin
                        citer_q <= citer_q - CNT_W'(1);
                        state   <= S_IDLE;
                    end
                end
                S_FETCH: begin
                    case (fidx_q)
                        IDX_W'(0): src_q <= ADDR_W'(mem_rdata);
                        IDX_W'(1): dst_q <= ADDR_W'(mem_rdata);
                        IDX_W'(2): begin
                            soff_q <= mem_rdata[WORD_W-1 -: OFF_W];
                            doff_q <= mem_rdata[OFF_W-1:0];
                        end
                        IDX_W'(3): minor_q <= mem_rdata;
                        IDX_W'(4): begin
                            citer_q  <= mem_rdata[CNT_W-1:0];
                            biter_q  <= mem_rdata[CNT_W-1:0];
                            word_q   <= mem_rdata[B_WORD];
                            irq_en_q <= mem_rdata[B_IRQ];
                            astop_q  <= mem_rdata[B_ASTOP];
                            sg_q     <= mem_rdata[B_SG];
                            mnl_q    <= mem_rdata[B_MNL];
                            mjl_q    <= mem_rdata[B_MJL];
                            mnch_q   <= mem_rdata[B_MNCH +: CH_W];
                            mjch_q   <= mem_rdata[B_MJCH +: CH_W];
                        end
                        IDX_W'(5): slast_q <= mem_rdata;
                        IDX_W'(6): dlast_q <= mem_rdata;
                        default: ;
                    endcase
                    fidx_q <= fidx_q + IDX_W'(1);
                    if (fidx_q == LAST_IDX) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // sticky interrupt: a new completion wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                   irq <= 1'b0;
        else if (state == S_END && last_iter && irq_en_q) irq <= 1'b1;
        else if (irq_clr)                             irq <= 1'b0;
    end

    assert_rdwr_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    assert_wr_after_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    assert_link_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> (!mem_re && !mem_we));
endmodule

// File: rtl/dma_desc_channel.sv
// Top: one descriptor-driven DMA channel, start collection plus engine.
// Assumes an external memory with same-cycle read data.
module dma_desc_channel
    import dma_ch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_load,
    input  logic [ADDR_W-1:0] boot_addr,
    input  logic              sw_start,
    input  logic              link_in,
    input  logic              hw_req,
    input  logic              req_en_set,
    input  logic              irq_clr,
    output logic              irq,
    output logic              req_en,
    output logic              busy,
    output logic              link_valid,
    output logic [CH_W-1:0]   link_ch,
    output logic              mem_re,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic go, accept, stop_clr;

    dma_ch_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .link_in(link_in),
        .hw_req(hw_req), .req_en_set(req_en_set), .stop_clr(stop_clr),
        .accept(accept), .go(go), .req_en(req_en)
    );

    dma_ch_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .boot_load(boot_load),
        .boot_addr(boot_addr), .irq_clr(irq_clr), .accept(accept),
        .stop_clr(stop_clr), .busy(busy), .irq(irq),
        .link_valid(link_valid), .link_ch(link_ch), .mem_re(mem_re),
        .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/dma_desc_channel_test.sv
// Bench: a behavioural model queues every expected memory access and link
// pulse; a monitor compares each one against the ports on every clock.
module dma_desc_channel_test;
    logic        clk = 0, rst_n = 0;
    logic        boot_load = 0, sw_start = 0, link_in = 0, hw_req = 0;
    logic        req_en_set = 0, irq_clr = 0;
    logic [31:0] boot_addr = 0;
    logic        irq, req_en, busy, link_valid, mem_re, mem_we, mem_word;
    logic [3:0]  link_ch;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    dma_desc_channel uut (
        .clk(clk), .rst_n(rst_n), .boot_load(boot_load), .boot_addr(boot_addr),
        .sw_start(sw_start), .link_in(link_in), .hw_req(hw_req),
        .req_en_set(req_en_set), .irq_clr(irq_clr), .irq(irq), .req_en(req_en),
        .busy(busy), .link_valid(link_valid), .link_ch(link_ch),
        .mem_re(mem_re), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // byte memory of the bench
    logic [7:0] mem [0:4095];
    always_comb begin
        if (mem_word)
            mem_rdata = {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                         mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
        else
            mem_rdata = {24'd0, mem[mem_addr[11:0]]};
    end
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata[7:0];
            if (mem_word) begin
                mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
                mem[mem_addr[11:0] + 12'd2] <= mem_wdata[23:16];
                mem[mem_addr[11:0] + 12'd3] <= mem_wdata[31:24];
            end
        end
    end

    int errors = 0, checks = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // expected access and link queues
    bit          q_we[$];
    logic [31:0] q_addr[$], q_data[$];
    bit          q_word[$];
    string       q_tag[$];
    int          l_ch[$];
    string       l_tag[$];

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {mem[a[11:0] + 12'd3], mem[a[11:0] + 12'd2],
                mem[a[11:0] + 12'd1], mem[a[11:0]]};
    endfunction

    task automatic push_acc(input bit we, input logic [31:0] a, input bit w,
                            input logic [31:0] d, input string t);
        q_we.push_back(we); q_addr.push_back(a); q_word.push_back(w);
        q_data.push_back(d); q_tag.push_back(t);
    endtask

    // model state of the active descriptor
    logic [31:0] m_src, m_dst, m_minor, m_slast, m_dlast;
    int          m_soff, m_doff, m_citer, m_biter, m_mnch, m_mjch;
    bit          m_word, m_irqen, m_astop, m_sg, m_mnl, m_mjl;
    bit          m_irq = 0, m_reqen = 0;

    task automatic model_fetch(input logic [31:0] a, input string t);
        logic [31:0] w2, w4;
        for (int i = 0; i < 8; i++) push_acc(0, a + 32'(4 * i), 1, 0, t);
        m_src = rd32(a); m_dst = rd32(a + 4);
        w2 = rd32(a + 8);
        m_soff = int'($signed(w2[31:16])); m_doff = int'($signed(w2[15:0]));
        m_minor = rd32(a + 12);
        w4 = rd32(a + 16);
        m_biter = int'(w4[15:0]); m_citer = m_biter;
        m_word = w4[16]; m_irqen = w4[17]; m_astop = w4[18]; m_sg = w4[19];
        m_mnl = w4[20]; m_mjl = w4[21];
        m_mnch = int'(w4[27:24]); m_mjch = int'(w4[31:28]);
        m_slast = rd32(a + 20); m_dlast = rd32(a + 24);
    endtask

    task automatic model_minor();
        int beat = m_word ? 4 : 1;
        int left = int'(m_minor);
        logic [31:0] d;
        do begin
            d = m_word ? rd32(m_src) : {24'd0, mem[m_src[11:0]]};
            push_acc(0, m_src, m_word, 0, "R2");
            push_acc(1, m_dst, m_word, d, "R1");
            m_src = m_src + 32'(m_soff);
            m_dst = m_dst + 32'(m_doff);
            left -= beat;
        end while (left > 0);
        if (m_citer <= 1) begin
            if (m_mjl) begin l_ch.push_back(m_mjch); l_tag.push_back("R5"); end
            if (m_irqen) m_irq = 1;
            if (m_astop) m_reqen = 0;
            m_src = m_src + m_slast;
            m_citer = m_biter;
            if (m_sg) model_fetch(m_dlast, "R6");
            else m_dst = m_dst + m_dlast;
        end else begin
            m_citer--;
            if (m_mnl) begin l_ch.push_back(m_mnch); l_tag.push_back("R4"); end
        end
    endtask

    // per-clock comparison of memory traffic and links
    always @(negedge clk) begin
        if (rst_n && (mem_re || mem_we)) begin
            if (q_we.size() == 0) chk(0, "R1", "unexpected access", mem_addr, 0);
            else begin
                chk(mem_we == q_we[0], q_tag[0], "access kind", 32'(mem_we), 32'(q_we[0]));
                chk(mem_addr == q_addr[0], q_tag[0], "address", mem_addr, q_addr[0]);
                chk(mem_word == q_word[0], "R1", "beat size", 32'(mem_word), 32'(q_word[0]));
                if (q_we[0]) chk(mem_wdata == q_data[0], "R1", "write data", mem_wdata, q_data[0]);
                void'(q_we.pop_front()); void'(q_addr.pop_front());
                void'(q_word.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
            end
        end
        if (rst_n && link_valid) begin
            if (l_ch.size() == 0) chk(0, "R4", "unexpected link", 32'(link_ch), 0);
            else begin
                chk(int'(link_ch) == l_ch[0], l_tag[0], "link channel", 32'(link_ch), 32'(l_ch[0]));
                void'(l_ch.pop_front()); void'(l_tag.pop_front());
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3, w4, w5, w6);
        logic [31:0] w [7];
        w = '{w0, w1, w2, w3, w4, w5, w6};
        for (int i = 0; i < 7; i++)
            for (int b = 0; b < 4; b++) mem[a[11:0] + 12'(4 * i + b)] = w[i][8*b +: 8];
    endtask

    task automatic wait_done();
        repeat (3) @(negedge clk);
        while (q_we.size() != 0 || l_ch.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(busy == 0, "R1", "idle after run", 32'(busy), 0);
    endtask

    task automatic pulse(input bit s, input bit l);
        @(negedge clk); sw_start = s; link_in = l;
        @(negedge clk); sw_start = 0; link_in = 0;
    endtask

    task automatic boot(input logic [31:0] a);
        model_fetch(a, "R11");
        @(negedge clk); boot_addr = a; boot_load = 1;
        @(negedge clk); boot_load = 0;
        wait_done();
    endtask

    task automatic check_flags(input string t);
        chk(irq == m_irq, t == "" ? "R8" : t, "irq", 32'(irq), 32'(m_irq));
        chk(req_en == m_reqen, "R7", "req_en", 32'(req_en), 32'(m_reqen));
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; m_irq = 0;
        @(negedge clk);
        chk(irq == 0, "R8", "irq after clear", 32'(irq), 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        // A: word beats, steps +4/+4, 8 bytes, 2 iterations, irq, links 3 and 5
        put_desc(32'h100, 32'h400, 32'h800, 32'h0004_0004, 8, 32'h5333_0002,
                 -32'sd16, -32'sd16);
        // B: byte beats, fixed destination, 3 bytes, 1 iteration
        put_desc(32'h140, 32'h500, 32'h900, 32'h0001_0000, 3, 32'h0000_0001,
                 -32'sd3, 0);
        // C: auto-stop, word beats, 2 iterations
        put_desc(32'h1C0, 32'h600, 32'hA00, 32'h0004_0004, 4, 32'h0005_0002,
                 -32'sd8, -32'sd8);
        // E: scatter-gather to F, negative source step, irq
        put_desc(32'h200, 32'h70C, 32'hB00, 32'hFFFC_0004, 8, 32'h000B_0001,
                 32'sd8, 32'h180);
        // F: plain word descriptor, no auto-stop
        put_desc(32'h180, 32'h540, 32'hC00, 32'h0004_0004, 4, 32'h0001_0001,
                 -32'sd4, -32'sd4);

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(irq == 0, "R11", "irq at reset", 32'(irq), 0);
        chk(req_en == 0, "R11", "req_en at reset", 32'(req_en), 0);
        chk(busy == 0, "R11", "busy at reset", 32'(busy), 0);
        chk(!link_valid && !mem_re && !mem_we, "R11", "port quiet at reset",
            {link_valid, mem_re, mem_we}, 0);

        boot(32'h100);
        model_minor(); pulse(1, 0); wait_done(); check_flags("R4");   // minor link R4
        model_minor(); pulse(1, 0); wait_done(); check_flags("R5");   // major, R3 R5 R8
        clear_irq();
        model_minor(); pulse(1, 0); wait_done(); check_flags("R3");   // rerun from start R3
        // R10: software and link start in the same cycle give one loop
        model_minor(); pulse(1, 1); wait_done(); check_flags("R10");
        clear_irq();
        // R10: start arriving during a running loop gives one more loop
        model_minor(); model_minor();
        pulse(1, 0); repeat (3) @(negedge clk); pulse(1, 0);
        wait_done(); check_flags("R10");
        clear_irq();

        // R9 link start, R2 byte beats with fixed destination
        boot(32'h140);
        model_minor(); pulse(0, 1); wait_done(); check_flags("R9");

        // R7 auto-stop with hw_req held high
        boot(32'h1C0);
        @(negedge clk); req_en_set = 1; m_reqen = 1;
        @(negedge clk); req_en_set = 0;
        chk(req_en == 1, "R9", "req_en after set", 32'(req_en), 1);
        model_minor(); model_minor();
        hw_req = 1;
        wait_done();
        repeat (10) @(negedge clk);
        check_flags("R7");
        // R9: hw_req ignored while req_en is 0
        repeat (20) @(negedge clk);
        chk(busy == 0, "R9", "no start from gated hw_req", 32'(busy), 0);
        hw_req = 0;

        // R6 scatter-gather from E into F
        boot(32'h200);
        model_minor(); pulse(1, 0); wait_done(); check_flags("R8");
        clear_irq();
        // F served by one cycle of hw_req; R7 clear keeps req_en
        @(negedge clk); req_en_set = 1; m_reqen = 1;
        @(negedge clk); req_en_set = 0;
        model_minor();
        hw_req = 1; @(negedge clk); hw_req = 0;
        wait_done(); check_flags("R7");
        model_minor(); pulse(1, 0); wait_done(); check_flags("R3");

        chk(q_we.size() == 0 && l_ch.size() == 0, "R1", "queues drained",
            32'(q_we.size() + l_ch.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule